// File: doc/BRIEF.md
# Memory Access Watchpoint Unit

This block sits beside a memory arbiter and watches every access the arbiter grants. It holds a bank of independent watch units (four by default). Software gives each unit an address window, a set of operation kinds and a set of client indices. When a granted access falls inside a unit's window, comes from an enabled client and is of an enabled kind, the unit latches a description of the access and raises its hit flag.

The hit flags are gated by a global enable mask and ORed into one interrupt line. Software reads the latched record through a small word-addressed register port, then clears the unit through either the unit's own clear register or the shared clear register. Register reads have one cycle of latency. The register address is split into a page field (upper bits) and a word offset (lower three bits). Pages 0 to 3 select a watch unit and page 4 selects the shared registers.

Top module: `memwatch`

## Requirements
- R1: After synchronous reset, every hit flag, the enable mask, every client record and `irq` are 0.
- R2: An access matches a unit's window only when window low <= address < window high (unit offset 0 holds low, offset 1 holds high).
- R3: An access matches only when bit `acc_client` of the unit's client mask (offset 3) is 1.
- R4: An access matches only when the bit of the unit's operation select (offset 2) for its kind is 1: bit 0 enables reads (`acc_write`=0) and bit 1 enables writes.
- R5: On the first match, the unit sets its hit flag. It latches the address (offset 5) and an info word (offset 6) holding the client index in bits 7:0, the write flag in bit 8 and the size in bits 23:16. It sets the client record (offset 7) to the one-hot bit of the client.
- R6: While the hit flag is set, further matches leave the address and info fields unchanged and only OR the client's bit into the client record.
- R7: Any write to unit offset 4 clears that unit's hit flag and client record. The next match captures a fresh record.
- R8: A write to shared offset 3 clears every unit whose data bit is 1 and leaves the other units unchanged.
- R9: Shared offset 0 is the enable mask (bit i for unit i). Shared offset 1 reads the raw hit flags and offset 2 reads the flags ANDed with the mask. `irq` is the OR of the masked flags, rises one cycle after the capturing edge and stays high until cleared.
- R10: Configuration registers read back what was written, one cycle after the address is presented.
- R11: One access can hit several units in the same cycle, and each unit captures it independently.
- R12: While `acc_valid` is 0, the access inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A granted access is present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_client | input | CIDX_W | Index of the requesting client |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_size | input | SIZE_W | Access size code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RADDR_W | Register word address {page, offset} |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, one cycle after address |
| irq | output | 1 | Combined masked watch interrupt |

## Verification
A unit whose window compare or mask gating is wrong shows at once: the raw status word reads back with the wrong bit one cycle after the access. A unit that overwrites its record after the first hit shows as a changed address or info word on the next read after the second access. A stale or uncleared client record shows as extra bits in the client word right after a clear. An interrupt that is wrongly latched or gated shows on `irq` two edges after the access or the clear.

// File: rtl/memwatch_pkg.sv
package memwatch_pkg;
  localparam int OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    U_LO    = 3'd0,
    U_HI    = 3'd1,
    U_OPS   = 3'd2,
    U_CMASK = 3'd3,
    U_ACK   = 3'd4,
    U_CADDR = 3'd5,
    U_CINFO = 3'd6,
    U_CCLI  = 3'd7
  } unit_off_e;

  typedef enum logic [OFF_W-1:0] {
    G_MASK = 3'd0,
    G_RAW  = 3'd1,
    G_MSK  = 3'd2,
    G_ACK  = 3'd3
  } glob_off_e;

  localparam int OP_RD_BIT     = 0;
  localparam int OP_WR_BIT     = 1;
  localparam int INFO_OP_BIT   = 8;
  localparam int INFO_SIZE_LSB = 16;
endpackage

// File: rtl/wp_match.sv
module wp_match #(
  parameter int ADDR_W  = 32,
  parameter int NCLIENT = 16,
  parameter int CIDX_W  = $clog2(NCLIENT)
) (
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CIDX_W-1:0]  client_i,
  input  logic               write_i,
  input  logic [ADDR_W-1:0]  lo_i,
  input  logic [ADDR_W-1:0]  hi_i,
  input  logic [1:0]         ops_i,
  input  logic [NCLIENT-1:0] cmask_i,
  output logic               match_o
);
  import memwatch_pkg::*;

  logic in_range, cli_ok, op_ok;

  always_comb begin
    in_range = (addr_i >= lo_i) && (addr_i < hi_i);
    cli_ok   = cmask_i[client_i];
    op_ok    = write_i ? ops_i[OP_WR_BIT] : ops_i[OP_RD_BIT];
    match_o  = valid_i && in_range && cli_ok && op_ok;
  end
endmodule

// File: rtl/wp_unit.sv
module wp_unit #(
  parameter int ADDR_W  = 32,
  parameter int NCLIENT = 16,
  parameter int CIDX_W  = $clog2(NCLIENT),
  parameter int SIZE_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              acc_valid,
  input  logic [ADDR_W-1:0]                 acc_addr,
  input  logic [CIDX_W-1:0]                 acc_client,
  input  logic                              acc_write,
  input  logic [SIZE_W-1:0]                 acc_size,
  input  logic                              cfg_we,
  input  logic [memwatch_pkg::OFF_W-1:0]    cfg_off,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  input  logic                              ack_ext,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic                              hit_o
);
  import memwatch_pkg::*;

  logic [ADDR_W-1:0]  lo_q, hi_q, cap_addr_q;
  logic [1:0]         ops_q;
  logic [NCLIENT-1:0] cmask_q, cap_cli_q, cli_bit;
  logic               hit_q, cap_wr_q, match, ack_now;
  logic [SIZE_W-1:0]  cap_size_q;
  logic [CIDX_W-1:0]  cap_first_q;

  wp_match #(.ADDR_W(ADDR_W), .NCLIENT(NCLIENT), .CIDX_W(CIDX_W)) u_match (
    .valid_i (acc_valid),
    .addr_i  (acc_addr),
    .client_i(acc_client),
    .write_i (acc_write),
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .ops_i   (ops_q),
    .cmask_i (cmask_q),
    .match_o (match)
  );

  assign cli_bit = NCLIENT'(1) << acc_client;
  assign ack_now = ack_ext || (cfg_we && (cfg_off == U_ACK));

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q        <= '0;
      hi_q        <= '0;
      ops_q       <= '0;
      cmask_q     <= '0;
      hit_q       <= 1'b0;
      cap_addr_q  <= '0;
      cap_wr_q    <= 1'b0;
      cap_size_q  <= '0;
      cap_first_q <= '0;
      cap_cli_q   <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_off)
          U_LO:    lo_q    <= cfg_wdata[ADDR_W-1:0];
          U_HI:    hi_q    <= cfg_wdata[ADDR_W-1:0];
          U_OPS:   ops_q   <= cfg_wdata[1:0];
          U_CMASK: cmask_q <= cfg_wdata[NCLIENT-1:0];
          default: ;
        endcase
      end
      if (match) begin
        if (!hit_q || ack_now) begin
          hit_q       <= 1'b1;
          cap_addr_q  <= acc_addr;
          cap_wr_q    <= acc_write;
          cap_size_q  <= acc_size;
          cap_first_q <= acc_client;
          cap_cli_q   <= cli_bit;
        end else begin
          cap_cli_q   <= cap_cli_q | cli_bit;
        end
      end else if (ack_now) begin
        hit_q     <= 1'b0;
        cap_cli_q <= '0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (cfg_off)
      U_LO:    rdata_o[ADDR_W-1:0]  = lo_q;
      U_HI:    rdata_o[ADDR_W-1:0]  = hi_q;
      U_OPS:   rdata_o[1:0]         = ops_q;
      U_CMASK: rdata_o[NCLIENT-1:0] = cmask_q;
      U_ACK:   rdata_o[0]           = hit_q;
      U_CADDR: rdata_o[ADDR_W-1:0]  = cap_addr_q;
      U_CINFO: begin
        rdata_o[CIDX_W-1:0]                    = cap_first_q;
        rdata_o[INFO_OP_BIT]                   = cap_wr_q;
        rdata_o[INFO_SIZE_LSB +: SIZE_W]       = cap_size_q;
      end
      U_CCLI:  rdata_o[NCLIENT-1:0] = cap_cli_q;
      default: rdata_o = '0;
    endcase
  end

  assign hit_o = hit_q;

  // R5: a set hit flag always carries at least one client in its record
  a_r5_record_nonempty: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> (cap_cli_q != '0));

  // R6: captured address stays put while the unit holds a hit
  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (hit_q && !ack_now) |=> $stable(cap_addr_q) && $stable(cap_first_q));

  // R6: client record only gains bits while held
  a_r6_clients_grow: assert property (@(posedge clk) disable iff (rst)
    (hit_q && !ack_now) |=> ((cap_cli_q & $past(cap_cli_q)) == $past(cap_cli_q)));

  // R7: a clear without a simultaneous match drops the hit flag
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_now && !match) |=> !hit_q && (cap_cli_q == '0));

  // R12: no valid access and no clear leaves the hit state untouched
  a_r12_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !ack_now) |=> $stable(hit_q) && $stable(cap_cli_q));
endmodule

// File: rtl/wp_csr.sv
module wp_csr #(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 32,
  parameter int PAGE_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_we,
  input  logic [PAGE_W-1:0]             page_i,
  input  logic [memwatch_pkg::OFF_W-1:0] off_i,
  input  logic [NUM_UNITS-1:0]          wbits_i,
  input  logic [NUM_UNITS-1:0]          hit_i,
  input  logic [NUM_UNITS*DATA_W-1:0]   unit_rdata_i,
  output logic [NUM_UNITS-1:0]          gack_o,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          irq_o
);
  import memwatch_pkg::*;

  localparam logic [PAGE_W-1:0] GPAGE = PAGE_W'(NUM_UNITS);

  logic [NUM_UNITS-1:0] mask_q, masked;
  logic [DATA_W-1:0]    rd_next;
  logic                 gsel;

  assign gsel   = (page_i == GPAGE);
  assign gack_o = (reg_we && gsel && (off_i == G_ACK)) ? wbits_i : '0;
  assign masked = hit_i & mask_q;

  always_comb begin
    rd_next = '0;
    if (gsel) begin
      case (off_i)
        G_MASK:  rd_next[NUM_UNITS-1:0] = mask_q;
        G_RAW:   rd_next[NUM_UNITS-1:0] = hit_i;
        G_MSK:   rd_next[NUM_UNITS-1:0] = masked;
        default: rd_next = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_UNITS; i++) begin
        if (page_i == PAGE_W'(i)) rd_next = unit_rdata_i[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (reg_we && gsel && (off_i == G_MASK)) mask_q <= wbits_i;
      rdata_o <= rd_next;
      irq_o   <= |masked;
    end
  end

  // R9: an enabled hit drives the interrupt on the next edge
  a_r9_irq_set: assert property (@(posedge clk) disable iff (rst)
    (|(hit_i & mask_q)) |=> irq_o);

  // R9: with no enabled hit the interrupt is low on the next edge
  a_r9_irq_clear: assert property (@(posedge clk) disable iff (rst)
    !(|(hit_i & mask_q)) |=> !irq_o);
endmodule

// File: rtl/memwatch.sv
module memwatch #(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 32,
  parameter int NCLIENT   = 16,
  parameter int CIDX_W    = $clog2(NCLIENT),
  parameter int SIZE_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PAGE_W    = $clog2(NUM_UNITS + 1),
  parameter int RADDR_W   = PAGE_W + memwatch_pkg::OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [CIDX_W-1:0]  acc_client,
  input  logic               acc_write,
  input  logic [SIZE_W-1:0]  acc_size,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  import memwatch_pkg::*;

  logic [PAGE_W-1:0]           page;
  logic [OFF_W-1:0]            off;
  logic [NUM_UNITS-1:0]        hits, gack;
  logic [NUM_UNITS*DATA_W-1:0] unit_rdata;

  assign page = reg_addr[RADDR_W-1:OFF_W];
  assign off  = reg_addr[OFF_W-1:0];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic we_u;
    assign we_u = reg_we && (page == PAGE_W'(u));
    wp_unit #(
      .ADDR_W(ADDR_W), .NCLIENT(NCLIENT), .CIDX_W(CIDX_W),
      .SIZE_W(SIZE_W), .DATA_W(DATA_W)
    ) u_unit (
      .clk       (clk),
      .rst       (rst),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_client(acc_client),
      .acc_write (acc_write),
      .acc_size  (acc_size),
      .cfg_we    (we_u),
      .cfg_off   (off),
      .cfg_wdata (reg_wdata),
      .ack_ext   (gack[u]),
      .rdata_o   (unit_rdata[u*DATA_W +: DATA_W]),
      .hit_o     (hits[u])
    );
  end

  wp_csr #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_csr (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .page_i      (page),
    .off_i       (off),
    .wbits_i     (reg_wdata[NUM_UNITS-1:0]),
    .hit_i       (hits),
    .unit_rdata_i(unit_rdata),
    .gack_o      (gack),
    .rdata_o     (reg_rdata),
    .irq_o       (irq)
  );
endmodule

// File: tb/memwatch_test.sv
module memwatch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [3:0]  acc_client = '0;
  logic        acc_write = 1'b0;
  logic [3:0]  acc_size = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #10 clk = ~clk;

  memwatch uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_client(acc_client), .acc_write(acc_write), .acc_size(acc_size),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  localparam logic [5:0] A_MASK = 6'h20, A_RAW = 6'h21, A_MSK = 6'h22, A_GACK = 6'h23;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: present a read address and queue the expected word
  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sbq.push_back('{e, tag});
    @(negedge clk);
  endtask

  // monitor: read data is registered at the edge after the address
  always @(posedge clk) begin
    item_t it;
    #5;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      chk(it.tag, reg_rdata, it.exp);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic acc(input logic v, input logic [31:0] a, input logic [3:0] c,
                     input logic w, input logic [3:0] s);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_client = c; acc_write = w; acc_size = s;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    @(negedge clk);
    chk(tag, {31'b0, irq}, {31'b0, e});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    rd(A_RAW, 32'h0, "R1 raw status");
    rd(A_MASK, 32'h0, "R1 mask");
    rd(6'd7, 32'h0, "R1 client record");
    irq_chk(1'b0, "R1 irq");

    // unit 0 window 0x1000..0x1FFF, reads+writes, clients 1 and 2
    wr(6'd0, 32'h1000); wr(6'd1, 32'h2000); wr(6'd2, 32'h3); wr(6'd3, 32'h6);
    wr(A_MASK, 32'h1);
    rd(6'd0, 32'h1000, "R10 lo");
    rd(6'd1, 32'h2000, "R10 hi");
    rd(6'd2, 32'h3, "R10 ops");
    rd(6'd3, 32'h6, "R10 cmask");
    rd(A_MASK, 32'h1, "R10 mask");

    acc(1'b0, 32'h1000, 4'd1, 1'b0, 4'd2);
    rd(A_RAW, 32'h0, "R12 invalid access ignored");

    acc(1'b1, 32'h0FFF, 4'd1, 1'b0, 4'd2);
    rd(A_RAW, 32'h0, "R2 below low");
    acc(1'b1, 32'h2000, 4'd1, 1'b0, 4'd2);
    rd(A_RAW, 32'h0, "R2 at high excluded");
    acc(1'b1, 32'h1000, 4'd1, 1'b0, 4'd2);
    rd(A_RAW, 32'h1, "R2 at low included");
    rd(6'd5, 32'h1000, "R5 captured address");
    rd(6'd6, 32'h0002_0001, "R5 captured info");
    rd(6'd7, 32'h2, "R5 client record");
    irq_chk(1'b1, "R9 irq raised");
    rd(A_MSK, 32'h1, "R9 masked status");

    acc(1'b1, 32'h1800, 4'd2, 1'b1, 4'd4);
    rd(6'd5, 32'h1000, "R6 address frozen");
    rd(6'd6, 32'h0002_0001, "R6 info frozen");
    rd(6'd7, 32'h6, "R6 client record ORed");

    acc(1'b1, 32'h1800, 4'd3, 1'b0, 4'd1);
    rd(6'd7, 32'h6, "R3 unmasked client ignored");

    wr(6'd4, 32'h0);
    rd(A_RAW, 32'h0, "R7 unit clear");
    rd(6'd7, 32'h0, "R7 record cleared");
    irq_chk(1'b0, "R9 irq dropped after clear");
    acc(1'b1, 32'h1FFF, 4'd2, 1'b1, 4'd3);
    rd(6'd5, 32'h1FFF, "R7 fresh address");
    rd(6'd6, 32'h0003_0102, "R7 fresh info");
    rd(6'd7, 32'h4, "R7 fresh record");

    // unit 1: writes only, all clients
    wr(6'd8, 32'h0); wr(6'd9, 32'h100); wr(6'd10, 32'h2); wr(6'd11, 32'hFFFF);
    acc(1'b1, 32'h10, 4'd5, 1'b0, 4'd1);
    rd(A_RAW, 32'h1, "R4 read not enabled");
    acc(1'b1, 32'h10, 4'd5, 1'b1, 4'd1);
    rd(A_RAW, 32'h3, "R4 write enabled");
    rd(A_MSK, 32'h1, "R9 masked excludes unit1");

    wr(A_GACK, 32'h1);
    rd(A_RAW, 32'h2, "R8 global clear unit0 only");
    rd(A_MSK, 32'h0, "R9 masked after clear");
    irq_chk(1'b0, "R9 irq low with unit1 masked");
    wr(A_MASK, 32'h3);
    rd(A_MSK, 32'h2, "R9 masked unit1");
    irq_chk(1'b1, "R9 irq from unit1");
    wr(A_GACK, 32'h2);
    rd(A_RAW, 32'h0, "R8 global clear unit1");
    irq_chk(1'b0, "R9 irq low after global clear");

    // units 2 and 3 overlap
    wr(6'd16, 32'h4000); wr(6'd17, 32'h5000); wr(6'd18, 32'h1); wr(6'd19, 32'h1);
    wr(6'd24, 32'h4800); wr(6'd25, 32'h4900); wr(6'd26, 32'h1); wr(6'd27, 32'h1);
    acc(1'b1, 32'h4850, 4'd0, 1'b0, 4'd7);
    rd(A_RAW, 32'hC, "R11 both units hit");
    rd(6'd21, 32'h4850, "R11 unit2 address");
    rd(6'd29, 32'h4850, "R11 unit3 address");
    acc(1'b1, 32'h4000, 4'd0, 1'b0, 4'd1);
    rd(6'd29, 32'h4850, "R11 unit3 unchanged");
    wr(A_GACK, 32'h4);
    rd(A_RAW, 32'h8, "R8 clear leaves unit3");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule